// File: doc/BRIEF.md
# Register Window Control Unit

This block keeps the bookkeeping for a windowed integer register file. A decode stage hands it save and restore requests, at most one per cycle. The block advances or retreats a current-window pointer. It maintains two occupancy counters, one for free windows and one for restorable windows, plus a third counter for windows that belong to another context. When a request cannot complete, the block raises a spill or fill flag and leaves all window state as it was. Trap software can then move a window to or from memory and retry the request.

Software loads the pointer and the three counters together through a small write port. The block accepts the load only when the counters sum to the window count minus two, and rejects it otherwise. A combinational mapping port converts an architectural register number in any window into a flat physical register index. Because outputs and inputs of neighbouring windows overlap, the register file itself needs only 8 + 16·NWIN entries.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset, `cwp` is 0, `free_cnt` is NWIN-2, `rest_cnt` and `other_cnt` are 0, and all four flag outputs are low.
- R2: A lone save request with `free_cnt` nonzero takes effect at the next clock edge. At that edge `cwp` becomes (cwp+1) mod NWIN, `free_cnt` drops by one and `rest_cnt` rises by one.
- R3: A lone restore request with `rest_cnt` nonzero takes effect at the next clock edge. At that edge `cwp` becomes (cwp-1) mod NWIN, `rest_cnt` drops by one and `free_cnt` rises by one.
- R4: A lone save request with `free_cnt` zero sets `spill` high for exactly the following cycle, and the pointer and counters stay unchanged.
- R5: A lone restore request with `rest_cnt` zero sets `fill` high for exactly the following cycle, and the pointer and counters stay unchanged.
- R6: Save and restore requested in the same cycle set `op_err` high for the following cycle, and the pointer and counters stay unchanged.
- R7: A write (`wr_en` high) whose three counter values sum to NWIN-2 loads `cwp`, `free_cnt`, `rest_cnt` and `other_cnt` at the next edge, and `wr_err` stays low.
- R8: A write whose counter values do not sum to NWIN-2 sets `wr_err` high for the following cycle, and the pointer and counters stay unchanged.
- R9: A window request in a cycle with `wr_en` high is ignored. Only the write acts, and `spill`, `fill` and `op_err` stay low.
- R10: `free_cnt + rest_cnt + other_cnt` equals NWIN-2 in every cycle.
- R11: Registers 0 to 7 map to physical index equal to the register number in every window, and `map_zero` is high exactly when the register number is 0.
- R12: Locals (registers 16 to 23) of window w map to 8 + 16·w + (r-16), so each window's locals are private.
- R13: Outputs (registers 8 to 15) of window w map to 16 + 16·w + (r-8). Inputs (registers 24 to 31) of window w map to the outputs of window (w-1) mod NWIN, so outputs of window NWIN-1 alias inputs of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Request to allocate a new window |
| restore_req | input | 1 | Request to release the current window |
| wr_en | input | 1 | Software load of pointer and counters |
| wr_cwp | input | PW | Pointer value to load |
| wr_free | input | PW | Free-window count to load |
| wr_rest | input | PW | Restorable count to load |
| wr_other | input | PW | Other-context count to load |
| cwp | output | PW | Current window pointer |
| free_cnt | output | PW | Windows available to save into |
| rest_cnt | output | PW | Windows available to restore |
| other_cnt | output | PW | Windows held for another context |
| spill | output | 1 | Save could not complete (one-cycle pulse) |
| fill | output | 1 | Restore could not complete (one-cycle pulse) |
| op_err | output | 1 | Simultaneous save and restore (pulse) |
| wr_err | output | 1 | Rejected software write (pulse) |
| map_win | input | PW | Window for the mapping lookup |
| map_reg | input | 5 | Architectural register number |
| map_phys | output | PHW | Physical register index |
| map_zero | output | 1 | Register reads as zero and ignores writes |

## Verification
The bench first runs a long chain of saves until the free counter is exhausted, which separates the counting path from the spill path. It then restores all the way back, which separates the fill path from the pointer decrement. A write that places the pointer at NWIN-1, followed by a save and a restore, tests wrap-around in both directions. Conflicting requests, good and bad writes, and writes that collide with a window request each test a different priority rule. The mapping port is swept over every window and register, and the register classes are compared against their closed forms, which exposes any error in window aliasing or in the wrap between the last window and window 0.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  // Physical layout: globals at 0..7, then 16 entries per window,
  // locals first, outputs second. Inputs live in the previous window's outputs.
  function automatic int unsigned phys_of(input int unsigned win,
                                          input int unsigned rnum,
                                          input int unsigned nwin);
    int unsigned base;
    base = 8 + 16 * win;
    if (rnum < 8)       return rnum;
    else if (rnum < 16) return base + 8 + (rnum - 8);
    else if (rnum < 24) return base + (rnum - 16);
    else                return 8 + 16 * ((win + nwin - 1) % nwin) + 8 + (rnum - 24);
  endfunction

  function automatic bit sum_matches(input int unsigned a,
                                     input int unsigned b,
                                     input int unsigned c,
                                     input int unsigned nwin);
    return (a + b + c) == (nwin - 2);
  endfunction

endpackage

// File: rtl/rwin_op_decode.sv
module rwin_op_decode #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_req,
  input  logic          restore_req,
  input  logic          wr_en,
  input  logic [PW-1:0] free_cnt,
  input  logic [PW-1:0] rest_cnt,
  output logic          do_save,
  output logic          do_restore,
  output logic          ovf_ev,
  output logic          unf_ev,
  output logic          clash_ev
);
  logic win_slot;
  logic lone_save;
  logic lone_rest;

  always_comb begin
    win_slot   = !wr_en;
    lone_save  = win_slot && save_req && !restore_req;
    lone_rest  = win_slot && restore_req && !save_req;
    clash_ev   = win_slot && save_req && restore_req;
    do_save    = lone_save && (free_cnt != '0);
    ovf_ev     = lone_save && (free_cnt == '0);
    do_restore = lone_rest && (rest_cnt != '0);
    unf_ev     = lone_rest && (rest_cnt == '0);
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_save, do_restore, ovf_ev, unf_ev, clash_ev})); // R6

  AST_WRITE_MASKS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(do_save || do_restore || ovf_ev || unf_ev || clash_ev)); // R9

endmodule

// File: rtl/rwin_wr_check.sv
module rwin_wr_check #(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input  logic          wr_en,
  input  logic [PW-1:0] wr_free,
  input  logic [PW-1:0] wr_rest,
  input  logic [PW-1:0] wr_other,
  output logic          wr_ok,
  output logic          wr_bad
);
  logic sum_good;

  always_comb begin
    sum_good = rwin_pkg::sum_matches(int'(wr_free), int'(wr_rest),
                                     int'(wr_other), NWIN);
    wr_ok  = wr_en && sum_good;
    wr_bad = wr_en && !sum_good;
  end

  always_comb begin
    if (wr_ok) begin
      AST_OK_IS_BALANCED: assert (int'(wr_free) + int'(wr_rest) + int'(wr_other) == NWIN - 2); // R7
    end
  end

endmodule

// File: rtl/rwin_state.sv
module rwin_state #(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_save,
  input  logic          do_restore,
  input  logic          ovf_ev,
  input  logic          unf_ev,
  input  logic          clash_ev,
  input  logic          wr_ok,
  input  logic          wr_bad,
  input  logic [PW-1:0] wr_cwp,
  input  logic [PW-1:0] wr_free,
  input  logic [PW-1:0] wr_rest,
  input  logic [PW-1:0] wr_other,
  output logic [PW-1:0] cwp,
  output logic [PW-1:0] free_cnt,
  output logic [PW-1:0] rest_cnt,
  output logic [PW-1:0] other_cnt,
  output logic          spill,
  output logic          fill,
  output logic          op_err,
  output logic          wr_err
);
  localparam logic [PW-1:0] FREE_RST = PW'(NWIN - 2);
  localparam int            SW       = PW + 2;

  logic [SW-1:0] count_sum;
  logic          state_hold;

  always_comb begin
    count_sum  = SW'(free_cnt) + SW'(rest_cnt) + SW'(other_cnt);
    state_hold = ovf_ev || unf_ev || clash_ev || wr_bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp       <= '0;
      free_cnt  <= FREE_RST;
      rest_cnt  <= '0;
      other_cnt <= '0;
    end else if (wr_ok) begin
      cwp       <= wr_cwp;
      free_cnt  <= wr_free;
      rest_cnt  <= wr_rest;
      other_cnt <= wr_other;
    end else if (do_save) begin
      cwp       <= cwp + 1'b1;
      free_cnt  <= free_cnt - 1'b1;
      rest_cnt  <= rest_cnt + 1'b1;
    end else if (do_restore) begin
      cwp       <= cwp - 1'b1;
      free_cnt  <= free_cnt + 1'b1;
      rest_cnt  <= rest_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spill  <= 1'b0;
      fill   <= 1'b0;
      op_err <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      spill  <= ovf_ev;
      fill   <= unf_ev;
      op_err <= clash_ev;
      wr_err <= wr_bad;
    end
  end

  AST_SUM_INVARIANT: assert property (@(posedge clk) disable iff (!rst_n)
    count_sum == SW'(NWIN - 2)); // R10

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_save |=> (cwp == PW'($past(cwp) + 1'b1)) && (rest_cnt == PW'($past(rest_cnt) + 1'b1))); // R2

  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |=> (cwp == PW'($past(cwp) - 1'b1)) && (free_cnt == PW'($past(free_cnt) + 1'b1))); // R3

  AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> spill && $stable(cwp) && $stable(free_cnt)); // R4

  AST_NO_UNDERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    unf_ev |=> fill && $stable(cwp) && $stable(rest_cnt)); // R5

  AST_BAD_WRITE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    state_hold |=> $stable(other_cnt) && $stable(cwp)); // R8

endmodule

// File: rtl/rwin_map.sv
module rwin_map #(
  parameter int NWIN = 8,
  parameter int PW   = 3,
  parameter int PHW  = 8
) (
  input  logic [PW-1:0]  map_win,
  input  logic [4:0]     map_reg,
  output logic [PHW-1:0] map_phys,
  output logic           map_zero
);
  localparam int PHYS_REGS = 8 + 16 * NWIN;

  always_comb begin
    map_phys = PHW'(rwin_pkg::phys_of(int'(map_win), int'(map_reg), NWIN));
    map_zero = (map_reg == 5'd0);
  end

  always_comb begin
    AST_PHYS_IN_RANGE: assert (int'(map_phys) < PHYS_REGS); // R13
    if (map_reg < 5'd8) begin
      AST_GLOBAL_SHARED: assert (map_phys == PHW'(map_reg)); // R11
    end else begin
      AST_WINDOWED_ABOVE_GLOBALS: assert (map_phys >= PHW'(8)); // R12
    end
  end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int NWIN = 8,
  parameter int PW   = (NWIN > 1) ? $clog2(NWIN) : 1,
  parameter int PHW  = $clog2(8 + 16 * NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           save_req,
  input  logic           restore_req,
  input  logic           wr_en,
  input  logic [PW-1:0]  wr_cwp,
  input  logic [PW-1:0]  wr_free,
  input  logic [PW-1:0]  wr_rest,
  input  logic [PW-1:0]  wr_other,
  output logic [PW-1:0]  cwp,
  output logic [PW-1:0]  free_cnt,
  output logic [PW-1:0]  rest_cnt,
  output logic [PW-1:0]  other_cnt,
  output logic           spill,
  output logic           fill,
  output logic           op_err,
  output logic           wr_err,
  input  logic [PW-1:0]  map_win,
  input  logic [4:0]     map_reg,
  output logic [PHW-1:0] map_phys,
  output logic           map_zero
);
  // NWIN must be a power of two between 2 and 32.
  logic do_save, do_restore, ovf_ev, unf_ev, clash_ev;
  logic wr_ok, wr_bad;

  rwin_op_decode #(.PW(PW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .restore_req(restore_req), .wr_en(wr_en),
    .free_cnt(free_cnt), .rest_cnt(rest_cnt),
    .do_save(do_save), .do_restore(do_restore),
    .ovf_ev(ovf_ev), .unf_ev(unf_ev), .clash_ev(clash_ev)
  );

  rwin_wr_check #(.NWIN(NWIN), .PW(PW)) u_wchk (
    .wr_en(wr_en), .wr_free(wr_free), .wr_rest(wr_rest), .wr_other(wr_other),
    .wr_ok(wr_ok), .wr_bad(wr_bad)
  );

  rwin_state #(.NWIN(NWIN), .PW(PW)) u_state (
    .clk(clk), .rst_n(rst_n),
    .do_save(do_save), .do_restore(do_restore),
    .ovf_ev(ovf_ev), .unf_ev(unf_ev), .clash_ev(clash_ev),
    .wr_ok(wr_ok), .wr_bad(wr_bad),
    .wr_cwp(wr_cwp), .wr_free(wr_free), .wr_rest(wr_rest), .wr_other(wr_other),
    .cwp(cwp), .free_cnt(free_cnt), .rest_cnt(rest_cnt), .other_cnt(other_cnt),
    .spill(spill), .fill(fill), .op_err(op_err), .wr_err(wr_err)
  );

  rwin_map #(.NWIN(NWIN), .PW(PW), .PHW(PHW)) u_map (
    .map_win(map_win), .map_reg(map_reg),
    .map_phys(map_phys), .map_zero(map_zero)
  );

endmodule

// File: tb/sim_rwin_ctrl.sv
module sim_rwin_ctrl;
  localparam int CLK_P = 10;
  localparam int NWIN  = 8;
  localparam int PW    = 3;
  localparam int PHW   = 8;
  localparam int EW    = 4 * PW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic save_req = 0, restore_req = 0, wr_en = 0;
  logic [PW-1:0] wr_cwp = '0, wr_free = '0, wr_rest = '0, wr_other = '0;
  logic [PW-1:0] cwp, free_cnt, rest_cnt, other_cnt;
  logic spill, fill, op_err, wr_err;
  logic [PW-1:0] map_win = '0;
  logic [4:0] map_reg = '0;
  logic [PHW-1:0] map_phys;
  logic map_zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_cwp = 0, m_free = NWIN - 2, m_rest = 0, m_other = 0;

  logic [EW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  rwin_ctrl #(.NWIN(NWIN)) u0 (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .restore_req(restore_req), .wr_en(wr_en),
    .wr_cwp(wr_cwp), .wr_free(wr_free), .wr_rest(wr_rest), .wr_other(wr_other),
    .cwp(cwp), .free_cnt(free_cnt), .rest_cnt(rest_cnt), .other_cnt(other_cnt),
    .spill(spill), .fill(fill), .op_err(op_err), .wr_err(wr_err),
    .map_win(map_win), .map_reg(map_reg), .map_phys(map_phys), .map_zero(map_zero)
  );

  function automatic logic [EW-1:0] pack(int c, int f, int r, int o,
                                         bit s, bit fl, bit oe, bit we);
    return {PW'(c), PW'(f), PW'(r), PW'(o), s, fl, oe, we};
  endfunction

  function automatic logic [EW-1:0] observed();
    return {cwp, free_cnt, rest_cnt, other_cnt, spill, fill, op_err, wr_err};
  endfunction

  task automatic check(input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h (cwp,free,rest,other,spill,fill,op_err,wr_err)",
               tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input string tag, input bit sv, input bit rs, input bit we,
                       input int wc, input int wf, input int wr, input int wo);
    bit s = 0, fl = 0, oe = 0, wer = 0;
    @(negedge clk);
    save_req = sv; restore_req = rs; wr_en = we;
    wr_cwp = PW'(wc); wr_free = PW'(wf); wr_rest = PW'(wr); wr_other = PW'(wo);
    if (we) begin
      if (wf + wr + wo == NWIN - 2) begin
        m_cwp = wc; m_free = wf; m_rest = wr; m_other = wo;
      end else wer = 1;
    end else if (sv && rs) oe = 1;
    else if (sv) begin
      if (m_free == 0) s = 1;
      else begin m_cwp = (m_cwp + 1) % NWIN; m_free--; m_rest++; end
    end else if (rs) begin
      if (m_rest == 0) fl = 1;
      else begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_rest--; m_free++; end
    end
    exp_q.push_back(pack(m_cwp, m_free, m_rest, m_other, s, fl, oe, wer));
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after every edge that consumed a queued stimulus.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [EW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, observed(), e);
        checks++;
        if (free_cnt + rest_cnt + other_cnt != NWIN - 2) begin
          fails++;
          $display("FAIL R10: actual sum=%0d expected=%0d",
                   free_cnt + rest_cnt + other_cnt, NWIN - 2);
        end
      end
    end
  end

  task automatic map_chk(input int w, input int r);
    int exp_p;
    bit exp_z;
    string tag;
    exp_z = (r == 0);
    if (r <= 7) begin exp_p = r; tag = "R11"; end
    else if (r >= 24) begin exp_p = 16 * ((w + NWIN - 1) % NWIN) + r - 8; tag = "R13 ins"; end
    else if (r >= 16) begin exp_p = 16 * w + r - 8; tag = "R12"; end
    else begin exp_p = 16 * w + r + 8; tag = "R13 outs"; end
    map_win = PW'(w); map_reg = 5'(r);
    #1;
    checks++;
    if (int'(map_phys) != exp_p || map_zero !== exp_z) begin
      fails++;
      $display("FAIL %s w=%0d r=%0d: actual=%0d/%0b expected=%0d/%0b",
               tag, w, r, map_phys, map_zero, exp_p, exp_z);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", observed(), pack(0, NWIN - 2, 0, 0, 0, 0, 0, 0));
    rst_n = 1'b1;

    for (int i = 0; i < NWIN - 2; i++) drive("R2 save", 1, 0, 0, 0, 0, 0, 0);
    drive("R4 spill", 1, 0, 0, 0, 0, 0, 0);
    drive("R4 spill clears", 0, 0, 0, 0, 0, 0, 0);
    drive("R6 clash", 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < NWIN - 2; i++) drive("R3 restore", 0, 1, 0, 0, 0, 0, 0);
    drive("R5 fill", 0, 1, 0, 0, 0, 0, 0);
    drive("R5 fill clears", 0, 0, 0, 0, 0, 0, 0);
    drive("R7 write wrap", 0, 0, 1, NWIN - 1, 3, 2, 1);
    drive("R2 save wrap", 1, 0, 0, 0, 0, 0, 0);
    drive("R3 restore wrap", 0, 1, 0, 0, 0, 0, 0);
    drive("R7 write zero ptr", 0, 0, 1, 0, 2, 2, 2);
    drive("R3 restore to top", 0, 1, 0, 0, 0, 0, 0);
    drive("R8 bad write", 0, 0, 1, 5, 1, 1, 1);
    drive("R8 bad write high", 0, 0, 1, 2, 7, 7, 7);
    drive("R9 write with save", 1, 0, 1, 4, 0, 6, 0);
    drive("R9 save spills after", 1, 0, 0, 0, 0, 0, 0);
    drive("R9 write with clash", 1, 1, 1, 1, 6, 0, 0);
    drive("R9 bad write with restore", 0, 1, 1, 3, 0, 0, 0);
    drive("R3 restore fills", 0, 1, 0, 0, 0, 0, 0);
    drive("idle", 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);

    for (int w = 0; w < NWIN; w++)
      for (int r = 0; r < 32; r++)
        map_chk(w, r);

    finish_run();
  end

endmodule